// File: doc/BRIEF.md
# Indexed Configuration Register File

This block holds a small bank of chip-level configuration registers behind an index/data port pair. The host first writes a register number to the index port. Later reads and writes on the data port then reach the register that this number selects. The register bank is open to the host only while an external configuration-mode flag is high. When the flag is low, the block acts as if the host were absent.

Each implemented register has three parameters: a writable-bit mask, a hard-reset default and a soft-reset default. A synchronous active-high hardware reset loads the hard defaults. The host can also request a soft reset by writing to a write-only control location. This produces a single-cycle internal pulse that loads the soft defaults. The index register keeps its value through a soft reset. The current register values are driven to downstream logic as one flat vector.

Top module: `cfg_regfile`

## Requirements
- R1: With `cfg_mode`=1, a write with `bus_sel`=1 and `bus_addr`=0 stores all 8 bits of `bus_wdata` as the index. A later read with `bus_addr`=0 returns that index.
- R2: With `cfg_mode`=0, writes to either port change neither the index nor any register, and reads on either port return 0x00.
- R3: With `bus_addr`=1, a data-port access acts only on the register whose index equals all 8 bits of the index register. Indices that differ in any bit (for example 0x87 against 0x07) do not alias.
- R4: Registers are implemented at indices 0x07, 0x20, 0x23 and 0x2E, with writable masks 0xFF, 0xFF, 0x0F and 0xF0. Bits outside a mask ignore writes and read as 0. Register k is driven on `cfg_q[8k+7:8k]`.
- R5: Every other index in 0x00–0xFF ignores data-port writes and reads back 0x00.
- R6: A data-port write with index 0x02 and `bus_wdata[0]`=1 raises `soft_rst_o` on the clock edge after the write, for exactly one cycle. Writing 0 to bit 0 gives no pulse. Reads at index 0x02 return 0x00.
- R7: The soft-reset pulse loads each register with its soft default: 0x00, 0xA5, 0x06 and 0x00 for the four registers in index order, each masked. The index register is left unchanged.
- R8: Hard reset (`rst`=1) loads each register with its hard default: 0x11, 0x5A, 0x03 and 0x80 in index order, each masked. It also clears the index, `bus_rdata` and `soft_rst_o`.
- R9: A data-port write in the cycle where `soft_rst_o` is high is ignored, including a repeated soft-reset request.
- R10: `bus_rdata` is registered. It shows the result of a read strobe on the clock edge after the strobe and is 0x00 after any edge with no accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| cfg_mode | input | 1 | Configuration mode; the ports are live only while high |
| bus_sel | input | 1 | Access select |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cfg_q | output | 32 | Current register values, register k in bits 8k+7:8k |
| soft_rst_o | output | 1 | One-cycle soft-reset pulse |

## Verification
Each result arrives on a fixed clock edge after its stimulus:
- An index or data write shows on `cfg_q` or on a later read one edge after the strobe.
- Read data shows on `bus_rdata` one edge after the strobe.
- `soft_rst_o` rises one edge after the write to index 0x02, and the soft defaults appear one edge after that.

The bench drives every strobe on a falling edge and samples on the next falling edge, which puts each sample exactly one rising edge after its cause. The soft-reset test issues its follow-up write on that same falling edge so that the write lands in the pulse cycle. The bench sweeps all 256 index values and compares each result with a model built from the index, mask and default values.

// File: rtl/cfg_regfile_pkg.sv
package cfg_regfile_pkg;
  localparam int          CFG_NREGS   = 4;
  localparam logic [7:0]  CFG_SRST_IX = 8'h02;
  // register k sits in bits 8k+7:8k
  localparam logic [CFG_NREGS*8-1:0] CFG_IX_DEF   = {8'h2E, 8'h23, 8'h20, 8'h07};
  localparam logic [CFG_NREGS*8-1:0] CFG_MASK_DEF = {8'hF0, 8'h0F, 8'hFF, 8'hFF};
  localparam logic [CFG_NREGS*8-1:0] CFG_HARD_DEF = {8'h80, 8'h03, 8'h5A, 8'h11};
  localparam logic [CFG_NREGS*8-1:0] CFG_SOFT_DEF = {8'h00, 8'h06, 8'hA5, 8'h00};
endpackage

// File: rtl/cfg_host_if.sv
module cfg_host_if #(
  parameter int         DW      = 8,
  parameter logic [7:0] SRST_IX = 8'h02
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_mode,
  input  logic          bus_sel,
  input  logic          bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] idx_q,
  output logic          data_wr,
  output logic          data_rd,
  output logic          idx_rd,
  output logic          soft_rst
);
  logic acc;
  logic idx_wr;

  assign acc     = cfg_mode & bus_sel;
  assign idx_wr  = acc & bus_wr & ~bus_addr;
  assign data_wr = acc & bus_wr & bus_addr & ~soft_rst;
  assign data_rd = acc & bus_rd & bus_addr;
  assign idx_rd  = acc & bus_rd & ~bus_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (idx_wr) begin
      idx_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_rst <= 1'b0;
    end else begin
      soft_rst <= data_wr && (idx_q == SRST_IX) && bus_wdata[0];
    end
  end

  // R6
  soft_pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !soft_rst);

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cfg_mode && bus_sel && bus_wr && !bus_addr) |=> $stable(idx_q));
endmodule

// File: rtl/cfg_reg_slice.sv
module cfg_reg_slice #(
  parameter int          DW   = 8,
  parameter logic [7:0]  IX   = 8'h00,
  parameter logic [DW-1:0] MASK = '1,
  parameter logic [DW-1:0] HARD = '0,
  parameter logic [DW-1:0] SOFT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic [7:0]    idx,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  output logic          hit,
  output logic [DW-1:0] q
);
  localparam logic [DW-1:0] HARD_M = HARD & MASK;
  localparam logic [DW-1:0] SOFT_M = SOFT & MASK;

  assign hit = (idx == IX);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= HARD_M;
    end else if (soft_rst) begin
      q <= SOFT_M;
    end else if (data_wr && hit) begin
      q <= wdata & MASK;
    end
  end

  // R4
  fixed_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (q & ~MASK) == '0);

  // R7
  soft_default_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> q == SOFT_M);

  // R8
  hard_default_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> q == HARD_M);
endmodule

// File: rtl/cfg_read_port.sv
module cfg_read_port #(
  parameter int NREGS = 4,
  parameter int DW    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                idx_rd,
  input  logic                data_rd,
  input  logic [DW-1:0]       idx_q,
  input  logic [NREGS-1:0]    hit,
  input  logic [NREGS*DW-1:0] regs,
  output logic [DW-1:0]       rdata
);
  logic [DW-1:0] sel_val;
  logic [DW-1:0] rdata_d;

  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (hit[i]) sel_val = sel_val | regs[i*DW +: DW];
    end
  end

  always_comb begin
    if (idx_rd)       rdata_d = idx_q;
    else if (data_rd) rdata_d = sel_val;
    else              rdata_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rdata_d;
  end

  // R10
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !(idx_rd || data_rd) |=> rdata == '0);

  // R3
  one_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_regfile_pkg::*;
#(
  parameter int                      NREGS   = CFG_NREGS,
  parameter logic [7:0]              SRST_IX = CFG_SRST_IX,
  parameter logic [NREGS*8-1:0]      REG_IX  = CFG_IX_DEF,
  parameter logic [NREGS*8-1:0]      REG_MSK = CFG_MASK_DEF,
  parameter logic [NREGS*8-1:0]      REG_HRD = CFG_HARD_DEF,
  parameter logic [NREGS*8-1:0]      REG_SFT = CFG_SOFT_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_mode,
  input  logic               bus_sel,
  input  logic               bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  output logic [NREGS*8-1:0] cfg_q,
  output logic               soft_rst_o
);
  localparam int DW = 8;

  logic [DW-1:0]    idx_q;
  logic             data_wr;
  logic             data_rd;
  logic             idx_rd;
  logic [NREGS-1:0] hit;

  cfg_host_if #(.DW(DW), .SRST_IX(SRST_IX)) u_host (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .bus_sel(bus_sel),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .idx_q(idx_q), .data_wr(data_wr),
    .data_rd(data_rd), .idx_rd(idx_rd), .soft_rst(soft_rst_o)
  );

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    cfg_reg_slice #(
      .DW(DW),
      .IX(REG_IX[g*8 +: 8]),
      .MASK(REG_MSK[g*DW +: DW]),
      .HARD(REG_HRD[g*DW +: DW]),
      .SOFT(REG_SFT[g*DW +: DW])
    ) u_slice (
      .clk(clk), .rst(rst), .soft_rst(soft_rst_o), .idx(idx_q),
      .data_wr(data_wr), .wdata(bus_wdata), .hit(hit[g]),
      .q(cfg_q[g*DW +: DW])
    );
  end

  cfg_read_port #(.NREGS(NREGS), .DW(DW)) u_rd (
    .clk(clk), .rst(rst), .idx_rd(idx_rd), .data_rd(data_rd),
    .idx_q(idx_q), .hit(hit), .regs(cfg_q), .rdata(bus_rdata)
  );

  // R2
  closed_mode_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_mode && !soft_rst_o) |=> $stable(cfg_q));

  // R2
  closed_mode_read_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode |=> bus_rdata == 8'h00);

  // R6
  soft_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(soft_rst_o) |-> $past(cfg_mode && bus_sel && bus_wr && bus_addr && bus_wdata[0]));
endmodule

// File: tb/test_cfg_regfile.sv
`timescale 1ns/1ps
module test_cfg_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_mode = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_addr = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [31:0] cfg_q;
  logic        soft_rst_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] m_ix  [4] = '{8'h07, 8'h20, 8'h23, 8'h2E};
  logic [7:0] m_msk [4] = '{8'hFF, 8'hFF, 8'h0F, 8'hF0};
  logic [7:0] m_hrd [4] = '{8'h11, 8'h5A, 8'h03, 8'h80};
  logic [7:0] m_sft [4] = '{8'h00, 8'hA5, 8'h06, 8'h00};
  logic [7:0] mdl   [4];

  always #2.5 clk = ~clk;

  cfg_regfile i_cfg_regfile (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .bus_sel(bus_sel),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_q(cfg_q),
    .soft_rst_o(soft_rst_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic chk_regs(input string req);
    for (int i = 0; i < 4; i++) chk(req, cfg_q[i*8 +: 8], mdl[i]);
  endtask

  function automatic int slot(input logic [7:0] ix);
    for (int i = 0; i < 4; i++) if (m_ix[i] == ix) return i;
    return -1;
  endfunction

  task automatic hard_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) mdl[i] = m_hrd[i] & m_msk[i];
  endtask

  initial begin
    logic [7:0] r;
    logic [7:0] keep_ix;
    @(negedge clk);
    hard_reset();
    // R8 reset state
    chk("R8", cfg_q[7:0], 8'h11);
    chk("R8", cfg_q[15:8], 8'h5A);
    chk("R8", cfg_q[23:16], 8'h03);
    chk("R8", cfg_q[31:24], 8'h80);
    chk("R8", bus_rdata, 8'h00);
    chk("R8", soft_rst_o, 1'b0);
    cfg_mode = 1'b1;
    rd(1'b0, r); chk("R8 index", r, 8'h00);

    // R1 index port
    wr(1'b0, 8'hA7); rd(1'b0, r); chk("R1", r, 8'hA7);
    wr(1'b0, 8'h5C); rd(1'b0, r); chk("R1", r, 8'h5C);

    // R3 R4 R5 full index sweep
    for (int k = 0; k < 256; k++) begin
      logic [7:0] p;
      int s;
      if (k == 2) continue;
      p = 8'(k) ^ 8'h3C;
      s = slot(8'(k));
      wr(1'b0, 8'(k));
      wr(1'b1, p);
      if (s >= 0) mdl[s] = p & m_msk[s];
      rd(1'b1, r);
      chk((s >= 0) ? "R4" : "R5", r, (s >= 0) ? (p & m_msk[s]) : 8'h00);
      chk_regs("R3");
    end

    // R6 bit0 clear gives no pulse, index 0x02 reads zero
    wr(1'b0, 8'h02);
    wr(1'b1, 8'hFE);
    chk("R6 no pulse", soft_rst_o, 1'b0);
    rd(1'b1, r); chk("R6 write-only", r, 8'h00);
    chk_regs("R6");

    // R10 registered read timing
    wr(1'b0, 8'h20);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 1'b1;
    #1 chk("R10 before edge", bus_rdata, 8'h00);
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
    chk("R10 after edge", bus_rdata, mdl[1]);
    @(negedge clk);
    chk("R10 idle", bus_rdata, 8'h00);

    // R2 closed mode
    wr(1'b0, 8'h23); keep_ix = 8'h23;
    cfg_mode = 1'b0;
    wr(1'b0, 8'h20);
    wr(1'b1, 8'h00);
    rd(1'b1, r); chk("R2 data read", r, 8'h00);
    rd(1'b0, r); chk("R2 index read", r, 8'h00);
    chk_regs("R2");
    cfg_mode = 1'b1;
    rd(1'b0, r); chk("R2 index kept", r, keep_ix);

    // R6 R7 R9 soft reset
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h01);
    chk("R6 pulse", soft_rst_o, 1'b1);
    wr(1'b1, 8'hFF);
    chk("R6 one cycle", soft_rst_o, 1'b0);
    for (int i = 0; i < 4; i++) mdl[i] = m_sft[i] & m_msk[i];
    chk_regs("R7");
    @(negedge clk);
    chk("R9 no retrigger", soft_rst_o, 1'b0);
    chk_regs("R9");
    rd(1'b0, r); chk("R7 index kept", r, 8'h02);

    // soft reset then write to a register afterwards works
    wr(1'b0, 8'h2E); wr(1'b1, 8'hFF); mdl[3] = 8'hF0;
    chk_regs("R4");

    // R8 hard reset mid-run
    hard_reset();
    chk_regs("R8");
    chk("R8 pulse", soft_rst_o, 1'b0);
    rd(1'b0, r); chk("R8 index clear", r, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule